// File: doc/BRIEF.md
# XGMII Link Fault Handler

This block sits between a transmit frame source and a 64-bit XGMII-style interface (64 data bits plus 8 control bits per clock, two 32-bit columns per word). On the receive side it watches for fault ordered sets and keeps a two-bit link status. Depending on that status, the transmit side either passes the source words through, replaces them with remote fault sequences, or sends continuous Idle.

It also produces a registered transmit-enable (xon) from a PHY transmit-ready input and the link status, and offers a single read-only status word at address 0. An elaboration parameter picks bidirectional, transmit-only or receive-only operation. Transmit-only mode ignores the fault status for xon and loops its own transmit word back as the receive input. Receive-only mode treats transmit-ready as permanently true.

Top module: `xgmii_link_fault_handler`

## Requirements
- R1: While rst_n is low, link_status is 00, xon is 0, and the transmit word is Idle: every byte 0x07, xgmii_txc = 0xFF.
- R2: A receive word carries a fault sequence when one of its 32-bit halves has control bits 0001 (lane 0 control, lanes 1..3 data), byte 0 = 0x9C, bytes 1 and 2 = 0x00, and byte 3 = 0x01 (local, type 1) or 0x02 (remote, type 2). If both halves qualify, the lower half decides the type. Every other word is a non-fault column. Each clock is one column.
- R3: link_status takes the value of the fault type on the edge that samples the fourth fault column of one type. That fourth column must lie at most 127 columns after the first of the four. A column of the other type, or a column past that limit, starts a new count at one.
- R4: A non-OK link_status returns to 00 on the edge that samples the 128th consecutive non-fault column. A fault column restarts that count.
- R5: While link_status is 00, the transmit word after an edge equals the source word sampled at that edge.
- R6: While link_status is 01, the transmit word after an edge is a remote fault sequence in both halves: xgmii_txd = 0x0200009C_0200009C, xgmii_txc = 0x11.
- R7: While link_status is 10, the transmit word after an edge is Idle.
- R8: xon after an edge is 1 exactly when phy_tx_ready sampled at that edge is 1 and link_status before that edge is 00.
- R9: reg_rdata at reg_addr 0 is {28 zeros, link_status, phy_tx_ready, xon} (xon in bit 0, ready in bit 1, status in bits 3:2). At any other address it is zero.
- R10: In transmit-only mode, xgmii_rxd/xgmii_rxc are ignored and the block's own transmit word is the receive input. xon then follows phy_tx_ready alone, whatever the status.
- R11: In receive-only mode, xon follows link_status alone, whatever phy_tx_ready is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_data | input | 64 | Transmit source data word |
| src_ctrl | input | 8 | Transmit source control bits |
| xgmii_txd | output | 64 | Transmit data toward the PHY |
| xgmii_txc | output | 8 | Transmit control toward the PHY |
| xgmii_rxd | input | 64 | Receive data from the PHY |
| xgmii_rxc | input | 8 | Receive control from the PHY |
| phy_tx_ready | input | 1 | PHY transmit path ready |
| link_status | output | 2 | 00 OK, 01 local fault, 10 remote fault |
| xon | output | 1 | Registered transmit enable |
| reg_addr | input | 4 | Status register address |
| reg_rdata | output | 32 | Status register read data |

## Verification
Two functions can collide on one edge. The clear counter can reach its last quiet column in the same cycle that a new fault column arrives. Separately, a status change and the transmit mux both act on the same edge, so the word leaving that edge must still follow the old status. The bench provokes the first case by sending a local fault exactly as the 128th column after entry. It provokes the second by letting the transmit-only loopback change status on consecutive edges. A behavioural reference model predicts status, transmit word, xon and read data every clock, so any off-by-one in either collision shows up as a mismatch.

// File: rtl/lfh_pkg.sv
package lfh_pkg;

    localparam int XG_DATA_W = 64;
    localparam int XG_CTRL_W = 8;
    localparam int COL_DATA_W = 32;
    localparam int COL_CTRL_W = 4;
    localparam int COLS_PER_WORD = XG_DATA_W / COL_DATA_W;

    typedef enum logic [1:0] {
        DIR_BIDIR   = 2'd0,
        DIR_TX_ONLY = 2'd1,
        DIR_RX_ONLY = 2'd2
    } lfh_dir_e;

    localparam logic [1:0] LS_OK     = 2'd0;
    localparam logic [1:0] LS_LOCAL  = 2'd1;
    localparam logic [1:0] LS_REMOTE = 2'd2;

    localparam logic [7:0] SEQ_CHAR  = 8'h9C;
    localparam logic [7:0] IDLE_CHAR = 8'h07;

    localparam logic [XG_DATA_W-1:0] IDLE_DATA = {8{IDLE_CHAR}};
    localparam logic [XG_CTRL_W-1:0] IDLE_CTRL = '1;
    localparam logic [XG_DATA_W-1:0] RF_DATA   = {2{8'h02, 8'h00, 8'h00, SEQ_CHAR}};
    localparam logic [XG_CTRL_W-1:0] RF_CTRL   = 8'h11;

endpackage

// File: rtl/lfh_fault_detect.sv
module lfh_fault_detect
    import lfh_pkg::*;
#(
    parameter int FAULT_COUNT = 4,
    parameter int WINDOW      = 128,
    parameter int CLEAR       = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [XG_DATA_W-1:0] rx_data_i,
    input  logic [XG_CTRL_W-1:0] rx_ctrl_i,
    output logic [1:0]           status_o,
    output logic                 fault_hit_o
);

    localparam int CNT_W = $clog2(FAULT_COUNT + 1);
    localparam int WIN_W = $clog2(WINDOW + 1);
    localparam int CLR_W = $clog2(CLEAR + 1);

    typedef struct packed {
        logic [1:0]       status;
        logic [1:0]       seq_type;
        logic [CNT_W-1:0] seq_cnt;
        logic [WIN_W-1:0] win;
        logic [CLR_W-1:0] clr;
    } det_state_t;

    det_state_t state_d, state_q;

    logic [COLS_PER_WORD-1:0] half_hit;
    logic [1:0]               half_type [COLS_PER_WORD];
    logic                     fault_hit;
    logic [1:0]               fault_type;

    // R2: per-column fault sequence recognition
    for (genvar h = 0; h < COLS_PER_WORD; h++) begin : g_col
        logic [COL_DATA_W-1:0] col_d;
        logic [COL_CTRL_W-1:0] col_c;
        assign col_d = rx_data_i[h*COL_DATA_W +: COL_DATA_W];
        assign col_c = rx_ctrl_i[h*COL_CTRL_W +: COL_CTRL_W];
        assign half_hit[h] = (col_c == 4'b0001) && (col_d[7:0] == SEQ_CHAR) &&
                             (col_d[23:8] == 16'h0000) &&
                             ((col_d[31:24] == 8'h01) || (col_d[31:24] == 8'h02));
        assign half_type[h] = col_d[25:24];
    end

    always_comb begin
        fault_hit  = |half_hit;
        fault_type = half_type[0];
        for (int h = COLS_PER_WORD - 1; h >= 0; h--) begin
            if (half_hit[h]) fault_type = half_type[h];
        end
    end

    always_comb begin
        logic [WIN_W-1:0] elapsed;
        logic             in_win;
        state_d = state_q;
        elapsed = state_q.win + WIN_W'(1);
        in_win  = (state_q.seq_cnt != '0) && (elapsed < WIN_W'(WINDOW));
        if (fault_hit) begin
            state_d.clr = '0;
            if (in_win && (fault_type == state_q.seq_type)) begin
                state_d.win = elapsed;
                if (state_q.seq_cnt == CNT_W'(FAULT_COUNT - 1)) begin
                    state_d.status  = fault_type;
                    state_d.seq_cnt = '0;
                end else begin
                    state_d.seq_cnt = state_q.seq_cnt + CNT_W'(1);
                end
            end else begin
                state_d.seq_type = fault_type;
                state_d.seq_cnt  = CNT_W'(1);
                state_d.win      = '0;
            end
        end else begin
            if (in_win) state_d.win = elapsed;
            else        state_d.seq_cnt = '0;
            if (state_q.status != LS_OK) begin
                if (state_q.clr == CLR_W'(CLEAR - 1)) begin
                    state_d.status = LS_OK;
                    state_d.clr    = '0;
                end else begin
                    state_d.clr = state_q.clr + CLR_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign status_o    = state_q.status;
    assign fault_hit_o = fault_hit;

    a_r1_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        status_o != 2'b11);

    a_r3_enter_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (status_o != $past(status_o)) && (status_o != LS_OK)
        |-> $past(fault_hit));

    a_r4_leave_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (status_o == LS_OK) && ($past(status_o) != LS_OK)
        |-> !$past(fault_hit));

endmodule

// File: rtl/lfh_tx_mux.sv
module lfh_tx_mux
    import lfh_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           status_i,
    input  logic [XG_DATA_W-1:0] src_data_i,
    input  logic [XG_CTRL_W-1:0] src_ctrl_i,
    output logic [XG_DATA_W-1:0] tx_data_o,
    output logic [XG_CTRL_W-1:0] tx_ctrl_o
);

    typedef struct packed {
        logic [XG_DATA_W-1:0] data;
        logic [XG_CTRL_W-1:0] ctrl;
    } tx_word_t;

    tx_word_t word_d, word_q;

    always_comb begin
        unique case (status_i)
            LS_OK:     word_d = '{data: src_data_i, ctrl: src_ctrl_i};
            LS_LOCAL:  word_d = '{data: RF_DATA,    ctrl: RF_CTRL};
            default:   word_d = '{data: IDLE_DATA,  ctrl: IDLE_CTRL};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '{data: IDLE_DATA, ctrl: IDLE_CTRL};
        else        word_q <= word_d;
    end

    assign tx_data_o = word_q.data;
    assign tx_ctrl_o = word_q.ctrl;

    a_r5_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(status_i) == LS_OK)
        |-> (tx_data_o == $past(src_data_i)) && (tx_ctrl_o == $past(src_ctrl_i)));

    a_r6_remote_seq_out: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(status_i) == LS_LOCAL)
        |-> (tx_ctrl_o == RF_CTRL) && (tx_data_o == RF_DATA));

    a_r7_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(status_i) == LS_REMOTE)
        |-> (tx_ctrl_o == IDLE_CTRL) && (tx_data_o == IDLE_DATA));

endmodule

// File: rtl/lfh_xon_gate.sv
module lfh_xon_gate
    import lfh_pkg::*;
#(
    parameter lfh_dir_e DIRECTION = DIR_BIDIR,
    parameter int       ADDR_W    = 4,
    parameter int       REG_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        status_i,
    input  logic              tx_ready_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    output logic              xon_o,
    output logic [REG_W-1:0]  reg_rdata_o
);

    localparam bit USE_STATUS = (DIRECTION != DIR_TX_ONLY);
    localparam bit USE_READY  = (DIRECTION != DIR_RX_ONLY);

    logic       xon_d, xon_q;
    logic [1:0] chk_status;
    logic       chk_ready;

    // a disabled condition takes the value that permits xon
    always_comb begin
        chk_status = USE_STATUS ? status_i : LS_OK;
        chk_ready  = USE_READY ? tx_ready_i : 1'b1;
        xon_d      = chk_ready && (chk_status == LS_OK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xon_q <= 1'b0;
        else        xon_q <= xon_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == '0) begin
            reg_rdata_o[0]   = xon_q;
            reg_rdata_o[1]   = tx_ready_i;
            reg_rdata_o[3:2] = status_i;
        end
    end

    assign xon_o = xon_q;

    a_r8_xon_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        xon_o && USE_READY |-> $past(tx_ready_i));

    a_r8_xon_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        xon_o && USE_STATUS |-> ($past(status_i) == LS_OK));

    a_r9_other_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i != '0) |-> (reg_rdata_o == '0));

endmodule

// File: rtl/xgmii_link_fault_handler.sv
module xgmii_link_fault_handler
    import lfh_pkg::*;
#(
    parameter lfh_dir_e DIRECTION   = DIR_BIDIR,
    parameter int       FAULT_COUNT = 4,
    parameter int       WINDOW      = 128,
    parameter int       CLEAR       = 128,
    parameter int       ADDR_W      = 4,
    parameter int       REG_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       src_data,
    input  logic [7:0]        src_ctrl,
    output logic [63:0]       xgmii_txd,
    output logic [7:0]        xgmii_txc,
    input  logic [63:0]       xgmii_rxd,
    input  logic [7:0]        xgmii_rxc,
    input  logic              phy_tx_ready,
    output logic [1:0]        link_status,
    output logic              xon,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic [REG_W-1:0]  reg_rdata
);

    logic [XG_DATA_W-1:0] tx_data, rx_data;
    logic [XG_CTRL_W-1:0] tx_ctrl, rx_ctrl;
    logic [1:0]           status;
    logic                 fault_hit;

    // R10: transmit-only loops the outgoing word back into the detector
    if (DIRECTION == DIR_TX_ONLY) begin : g_loop
        assign rx_data = tx_data;
        assign rx_ctrl = tx_ctrl;
    end else begin : g_phy
        assign rx_data = xgmii_rxd;
        assign rx_ctrl = xgmii_rxc;
    end

    lfh_fault_detect #(
        .FAULT_COUNT (FAULT_COUNT),
        .WINDOW      (WINDOW),
        .CLEAR       (CLEAR)
    ) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_data_i   (rx_data),
        .rx_ctrl_i   (rx_ctrl),
        .status_o    (status),
        .fault_hit_o (fault_hit)
    );

    lfh_tx_mux u_txmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_i   (status),
        .src_data_i (src_data),
        .src_ctrl_i (src_ctrl),
        .tx_data_o  (tx_data),
        .tx_ctrl_o  (tx_ctrl)
    );

    lfh_xon_gate #(
        .DIRECTION (DIRECTION),
        .ADDR_W    (ADDR_W),
        .REG_W     (REG_W)
    ) u_xon (
        .clk         (clk),
        .rst_n       (rst_n),
        .status_i    (status),
        .tx_ready_i  (phy_tx_ready),
        .reg_addr_i  (reg_addr),
        .xon_o       (xon),
        .reg_rdata_o (reg_rdata)
    );

    assign xgmii_txd   = tx_data;
    assign xgmii_txc   = tx_ctrl;
    assign link_status = status;

    // R8: xon is never high in the cycle after a fault status was held (unless status is masked)
    a_r8_xon_off_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(fault_hit) && (DIRECTION != DIR_TX_ONLY) && (status != LS_OK)
        |=> !xon);

endmodule

// File: tb/xgmii_link_fault_handler_tb.sv
`timescale 1ns/1ps
module xgmii_link_fault_handler_tb;
    import lfh_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic [63:0] src_data, rxd;
    logic [7:0]  src_ctrl, rxc;
    logic        ready;
    logic [3:0]  addr;
    int          src_mode;
    int          cyc;

    logic [63:0] txd [3];
    logic [7:0]  txc [3];
    logic [1:0]  ls  [3];
    logic        xo  [3];
    logic [31:0] rd  [3];

    int checks = 0;
    int failures = 0;
    bit done = 0;

    xgmii_link_fault_handler #(.DIRECTION(DIR_BIDIR)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_data(src_data), .src_ctrl(src_ctrl),
        .xgmii_txd(txd[0]), .xgmii_txc(txc[0]), .xgmii_rxd(rxd), .xgmii_rxc(rxc),
        .phy_tx_ready(ready), .link_status(ls[0]), .xon(xo[0]),
        .reg_addr(addr), .reg_rdata(rd[0]));

    xgmii_link_fault_handler #(.DIRECTION(DIR_TX_ONLY)) u_dut_tx (
        .clk(clk), .rst_n(rst_n), .src_data(src_data), .src_ctrl(src_ctrl),
        .xgmii_txd(txd[1]), .xgmii_txc(txc[1]), .xgmii_rxd(rxd), .xgmii_rxc(rxc),
        .phy_tx_ready(ready), .link_status(ls[1]), .xon(xo[1]),
        .reg_addr(addr), .reg_rdata(rd[1]));

    xgmii_link_fault_handler #(.DIRECTION(DIR_RX_ONLY)) u_dut_rx (
        .clk(clk), .rst_n(rst_n), .src_data(src_data), .src_ctrl(src_ctrl),
        .xgmii_txd(txd[2]), .xgmii_txc(txc[2]), .xgmii_rxd(rxd), .xgmii_rxc(rxc),
        .phy_tx_ready(ready), .link_status(ls[2]), .xon(xo[2]),
        .reg_addr(addr), .reg_rdata(rd[2]));

    // ---------------- reference model ----------------
    int          m_st [3], m_type [3], m_cnt [3], m_win [3], m_clr [3];
    bit          m_xon [3];
    logic [63:0] m_txd [3];
    logic [7:0]  m_txc [3];
    string       m_txtag [3];

    function automatic int classify(input logic [63:0] d, input logic [7:0] c);
        for (int h = 0; h < 2; h++) begin
            logic [31:0] w;
            w = d[32*h +: 32];
            if (c[4*h +: 4] == 4'b0001 && w[7:0] == 8'h9C && w[23:8] == 16'h0 &&
                (w[31:24] == 8'h01 || w[31:24] == 8'h02))
                return int'(w[31:24]);
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (!rst_n) begin
                m_st[i] = 0; m_type[i] = 0; m_cnt[i] = 0; m_win[i] = 0; m_clr[i] = 0;
                m_xon[i] = 0; m_txd[i] = {8{8'h07}}; m_txc[i] = 8'hFF; m_txtag[i] = "R1";
            end else begin
                int old_st, t;
                logic [63:0] rw;
                logic [7:0]  rc;
                old_st = m_st[i];
                rw = (i == 1) ? m_txd[i] : rxd;
                rc = (i == 1) ? m_txc[i] : rxc;
                t  = classify(rw, rc);
                if (old_st == 0) begin
                    m_txd[i] = src_data; m_txc[i] = src_ctrl; m_txtag[i] = "R5";
                end else if (old_st == 1) begin
                    m_txd[i] = 64'h0200009C_0200009C; m_txc[i] = 8'h11; m_txtag[i] = "R6";
                end else begin
                    m_txd[i] = {8{8'h07}}; m_txc[i] = 8'hFF; m_txtag[i] = "R7";
                end
                m_xon[i] = ((i == 2) ? 1'b1 : ready) && ((i == 1) ? 1'b1 : (old_st == 0));
                if (t != 0) begin
                    m_clr[i] = 0;
                    if (m_cnt[i] > 0 && t == m_type[i] && m_win[i] + 1 < 128) begin
                        m_win[i]++;
                        m_cnt[i]++;
                        if (m_cnt[i] == 4) begin m_st[i] = t; m_cnt[i] = 0; end
                    end else begin
                        m_type[i] = t; m_cnt[i] = 1; m_win[i] = 0;
                    end
                end else begin
                    if (m_cnt[i] > 0 && m_win[i] + 1 < 128) m_win[i]++;
                    else m_cnt[i] = 0;
                    if (old_st != 0) begin
                        m_clr[i]++;
                        if (m_clr[i] == 128) begin m_st[i] = 0; m_clr[i] = 0; end
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-clock comparison, 5 ns after the active edge
    always begin
        @(posedge clk);
        #5;
        if (rst_n && !done) begin
            for (int i = 0; i < 3; i++) begin
                logic [31:0] exp_rd;
                string st_tag, xon_tag;
                st_tag  = (i == 1) ? "R10" : ((m_st[i] != 0) ? "R3" : "R4");
                xon_tag = (i == 0) ? "R8" : ((i == 1) ? "R10" : "R11");
                exp_rd = '0;
                if (addr == 0) exp_rd = {28'b0, 2'(m_st[i]), ready, m_xon[i]};
                chk(ls[i] == 2'(m_st[i]), st_tag, $sformatf("inst%0d status", i),
                    64'(ls[i]), 64'(m_st[i]));
                chk(txd[i] === m_txd[i] && txc[i] === m_txc[i], m_txtag[i],
                    $sformatf("inst%0d tx word", i), txd[i], m_txd[i]);
                chk(xo[i] === m_xon[i], xon_tag, $sformatf("inst%0d xon", i),
                    64'(xo[i]), 64'(m_xon[i]));
                chk(rd[i] === exp_rd, "R9", $sformatf("inst%0d reg", i),
                    64'(rd[i]), 64'(exp_rd));
            end
        end
    end

    // ---------------- stimulus ----------------
    always @(negedge clk) begin
        cyc++;
        if (src_mode == 1) begin
            src_data <= 64'h00000000_0100009C;
            src_ctrl <= 8'h01;
        end else begin
            src_data <= {32'(cyc) * 32'h9E3779B1, ~32'(cyc)};
            src_ctrl <= 8'h00;
        end
    end

    task automatic rx_idle();
        rxd = {8{8'h07}};
        rxc = 8'hFF;
    endtask

    task automatic rx_fault(input int t, input int h);
        rx_idle();
        rxd[32*h +: 32] = {8'(t), 16'h0000, 8'h9C};
        rxc[4*h +: 4]   = 4'b0001;
        @(negedge clk);
        rx_idle();
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0; ready = 1; addr = 0; src_mode = 0; cyc = 0;
        src_data = '0; src_ctrl = '0;
        rx_idle();
        gap(4);
        // R1: reset state on every instance
        for (int i = 0; i < 3; i++) begin
            chk(ls[i] == 2'b00, "R1", "reset status", 64'(ls[i]), 64'd0);
            chk(xo[i] == 1'b0, "R1", "reset xon", 64'(xo[i]), 64'd0);
            chk(txd[i] == {8{8'h07}} && txc[i] == 8'hFF, "R1", "reset tx word", txd[i], {8{8'h07}});
        end
        rst_n = 1;
        gap(30);

        // ready toggling, register at other addresses (R8, R9)
        for (int k = 0; k < 12; k++) begin
            ready = k[0];
            addr  = (k % 3 == 0) ? 4'd0 : 4'(k);
            gap(3);
        end
        addr = 4'd5;
        gap(1);
        chk(rd[0] == 32'h0, "R9", "nonzero address reads zero", 64'(rd[0]), 64'd0);
        addr = 0; ready = 1;

        // R11: receive-only ignores ready
        ready = 0;
        gap(3);
        chk(xo[2] == 1'b1, "R11", "rx-only xon with ready low", 64'(xo[2]), 64'd1);
        chk(xo[0] == 1'b0, "R8", "bidir xon with ready low", 64'(xo[0]), 64'd0);
        ready = 1;
        gap(3);

        // R2: near-miss columns are not faults
        rxd = {32'h07070707, 32'h0100009C}; rxc = 8'hF3; gap(1);
        rxd = {32'h07070707, 32'h0101009C}; rxc = 8'hF1; gap(1);
        rxd = {32'h07070707, 32'h0300009C}; rxc = 8'hF1; gap(1);
        rxd = {32'h07070707, 32'h0100009D}; rxc = 8'hF1; gap(1);
        rxd = {32'h07070707, 32'h0100009C}; rxc = 8'hF0; gap(1);
        rx_idle();
        gap(2);
        chk(ls[0] == 2'b00, "R2", "near-miss columns ignored", 64'(ls[0]), 64'd0);
        gap(130);

        // R3: local entry, columns 0,40,80,120, upper and lower halves
        rx_fault(1, 0); gap(39);
        rx_fault(1, 1); gap(39);
        rx_fault(1, 0); gap(39);
        chk(ls[0] == 2'b00, "R3", "three faults do not enter", 64'(ls[0]), 64'd0);
        rx_fault(1, 1);
        chk(ls[0] == 2'b01, "R3", "local fault entered", 64'(ls[0]), 64'd1);
        chk(ls[1] == 2'b00, "R10", "tx-only ignores rx faults", 64'(ls[1]), 64'd0);
        gap(1);
        chk(xo[0] == 1'b0, "R8", "xon drops in fault", 64'(xo[0]), 64'd0);
        chk(xo[1] == 1'b1, "R10", "tx-only xon ignores status", 64'(xo[1]), 64'd1);
        chk(txc[0] == 8'h11, "R6", "remote sequence sent", 64'(txc[0]), 64'h11);
        // R4: fault on the 128th column keeps the state
        gap(126);
        rx_fault(1, 0);
        chk(ls[0] == 2'b01, "R4", "fault at last quiet column keeps state", 64'(ls[0]), 64'd1);
        gap(127);
        chk(ls[0] == 2'b01, "R4", "127 quiet columns keep state", 64'(ls[0]), 64'd1);
        gap(1);
        chk(ls[0] == 2'b00, "R4", "128 quiet columns clear", 64'(ls[0]), 64'd0);
        gap(130);

        // R3: window expiry at column 128, then entry with the restart
        rx_fault(2, 0); gap(49);
        rx_fault(2, 0); gap(49);
        rx_fault(2, 0); gap(27);
        rx_fault(2, 0);
        chk(ls[0] == 2'b00, "R3", "fourth fault outside window", 64'(ls[0]), 64'd0);
        rx_fault(2, 0);
        rx_fault(2, 0);
        rx_fault(2, 1);
        chk(ls[0] == 2'b10, "R3", "remote fault entered", 64'(ls[0]), 64'd2);
        gap(1);
        chk(txd[0] == {8{8'h07}}, "R7", "idle sent in remote fault", txd[0], {8{8'h07}});
        // local columns while remote: type switch restarts
        rx_fault(1, 0); rx_fault(1, 0); rx_fault(1, 0);
        chk(ls[0] == 2'b10, "R3", "three local keep remote", 64'(ls[0]), 64'd2);
        gap(130);
        chk(ls[0] == 2'b00, "R4", "remote cleared", 64'(ls[0]), 64'd0);
        gap(130);

        // R3: mixed types restart the count
        rx_fault(1, 0); rx_fault(1, 0); rx_fault(2, 0); rx_fault(1, 0); rx_fault(1, 0);
        gap(1);
        chk(ls[0] == 2'b00, "R3", "interleaved types do not enter", 64'(ls[0]), 64'd0);
        gap(130);

        // R3: fourth fault at column 127 is inside the window
        rx_fault(1, 0); gap(49);
        rx_fault(1, 0); gap(49);
        rx_fault(1, 0); gap(26);
        rx_fault(1, 0);
        chk(ls[0] == 2'b01, "R3", "fourth fault at column 127 enters", 64'(ls[0]), 64'd1);
        gap(135);

        // R10: transmit-only loopback of the source's own fault columns
        src_mode = 1;
        gap(4);
        src_mode = 0;
        gap(4);
        chk(ls[1] != 2'b00, "R10", "loopback detects own faults", 64'(ls[1]), 64'd1);
        chk(ls[0] == 2'b00, "R10", "bidir not affected by own tx", 64'(ls[0]), 64'd0);
        gap(150);
        chk(ls[1] == 2'b00, "R10", "loopback clears", 64'(ls[1]), 64'd0);

        gap(5);
        finish_run();
    end

endmodule